// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog that supervises software through a small write-only register port. Two preload values set the lengths of two consecutive countdown stages. Software keeps the timer from expiring by issuing reload (kick) commands. If the first stage runs out, the second stage starts. If the second stage also runs out, the block records a sticky timeout flag. It can also raise a one-cycle reset request, marked as warm or cold, and it can invert a toggle output.

The preloads and the reload command are guarded by a two-byte key. That key must be written just before every guarded write. A lock bit, once set, freezes the enable and the configuration until hardware reset, so software can no longer stop the timer. Each preload sits above a run of low counter bits. The length of that run is set by a prescaler select bit, which gives either a coarse or a fine time unit per preload count.

Top module: `keyed_wdt`

## Requirements
- R1: A write to offset 0x00 (first preload), 0x04 (second preload) or 0x0D (reload command) takes effect only if the two writes just before it were 0x80 and then 0x86 to offset 0x0C. Write data for every register is taken from the low bits of `wr_data`.
- R2: One completed key allows one guarded write. A second guarded write without a new key is ignored.
- R3: The key is cancelled in two cases: a write to 0x0C other than the expected next key byte, or a write to any other offset between the key and the guarded write. The guarded write that follows is then ignored.
- R4: A stage loaded with preload value p lasts (p+1)·2^S clock cycles. S is LONG_SH when configuration bit 2 (offset 0x10) is clear and SHORT_SH when it is set. Counting starts on the edge that enables the timer or kicks it.
- R5: Writing bit 0 of the reload command reloads the first stage and restarts the countdown. When the timer is disabled, this only loads the counter and does not start it.
- R6: When the second stage expires, `tout_flag` is set. If configuration bit 4 is set, `rst_req` is high for exactly one cycle. The first stage then restarts at once.
- R7: Writing bit 1 of the reload command clears `tout_flag`. Without the key, the flag stays set.
- R8: Configuration bit 3 drives `rst_warm` (1 means warm, 0 means cold). `tog_out` inverts at each second-stage expiry unless configuration bit 5 is set.
- R9: At offset 0x18, bit 1 is the enable and bit 0 is the lock. Once the lock is set, writes to 0x18 and 0x10 are ignored until hardware reset.
- R10: If a guarded kick lands on the same edge as a second-stage expiry, the kick wins. No timeout is recorded, and a full first stage begins.
- R11: After reset, the timer is disabled and unlocked, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low hardware reset, clears everything including the lock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register byte offset |
| wr_data | input | DW | Write data, DW = max(PV_W, 8) |
| rst_req | output | 1 | One-cycle reset request on second-stage expiry |
| rst_warm | output | 1 | Reset kind: 1 warm, 0 cold |
| tout_flag | output | 1 | Sticky timeout-occurred flag |
| tog_out | output | 1 | Level inverted at each second-stage expiry |

## Verification
The two functions that can meet in one cycle are the second-stage expiry and a guarded kick. The bench counts clock edges from the enable, places the two key bytes on the two edges before expiry, and lands the reload command exactly on the expiry edge. The collision is judged at the ports: right after that edge, `rst_req` and `tout_flag` must both be low, and the next timeout must arrive one full period later. A near-exhaustive sweep over small preload values and both prescaler settings checks the arithmetic timing. Separate runs check the key, the one-shot behaviour of the key, the lock and the flag clear.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int PV_W     = 20,
  parameter int LONG_SH  = 15,
  parameter int SHORT_SH = 5,
  localparam int DW      = (PV_W > 8) ? PV_W : 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [4:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          rst_req,
  output logic          rst_warm,
  output logic          tout_flag,
  output logic          tog_out
);
  localparam int CW = PV_W + LONG_SH;
  localparam logic [4:0] A_PV1 = 5'h00, A_PV2 = 5'h04, A_KEY = 5'h0C,
                         A_RLD = 5'h0D, A_CFG = 5'h10, A_LCK = 5'h18;

  logic [1:0]      key_st;
  logic [PV_W-1:0] pv1, pv2;
  logic [5:2]      cfg;
  logic            locked, en, stage2;
  logic [CW-1:0]   cnt;

  function automatic logic [CW-1:0] load_val(input logic [PV_W-1:0] pv, input logic fine);
    logic [CW-1:0] w;
    w = CW'(pv);
    if (fine) return (w << SHORT_SH) | ((CW'(1) << SHORT_SH) - CW'(1));
    return (w << LONG_SH) | ((CW'(1) << LONG_SH) - CW'(1));
  endfunction

  wire armed  = (key_st == 2'd2);
  wire gwr    = wr_en && armed;
  wire kick   = gwr && (wr_addr == A_RLD) && wr_data[0];
  wire clr    = gwr && (wr_addr == A_RLD) && wr_data[1];
  wire expire = en && (cnt == '0) && !kick;
  wire fire   = expire && stage2;
  wire cfg_ok = wr_en && !locked;

  assign rst_warm = cfg[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_st <= 2'd0;
    else if (wr_en) begin
      if (wr_addr != A_KEY)        key_st <= 2'd0;
      else if (wr_data == DW'(8'h80)) key_st <= 2'd1;
      else if (key_st == 2'd1 && wr_data == DW'(8'h86)) key_st <= 2'd2;
      else                         key_st <= 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv1 <= '0;
      pv2 <= '0;
    end else if (gwr) begin
      if (wr_addr == A_PV1) pv1 <= wr_data[PV_W-1:0];
      if (wr_addr == A_PV2) pv2 <= wr_data[PV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      locked <= 1'b0;
      en     <= 1'b0;
    end else if (cfg_ok) begin
      if (wr_addr == A_CFG) cfg <= wr_data[5:2];
      if (wr_addr == A_LCK) begin
        locked <= wr_data[0];
        en     <= wr_data[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      stage2 <= 1'b0;
    end else if (kick) begin
      cnt    <= load_val(pv1, cfg[2]);
      stage2 <= 1'b0;
    end else if (expire) begin
      cnt    <= stage2 ? load_val(pv1, cfg[2]) : load_val(pv2, cfg[2]);
      stage2 <= !stage2;
    end else if (en) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_flag <= 1'b0;
      rst_req   <= 1'b0;
      tog_out   <= 1'b0;
    end else begin
      if (fire)     tout_flag <= 1'b1;
      else if (clr) tout_flag <= 1'b0;
      rst_req <= fire && cfg[4];
      if (fire && !cfg[5]) tog_out <= !tog_out;
    end
  end

  assert_guard_pv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed) |=> ($stable(pv1) && $stable(pv2)));
  assert_one_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gwr && wr_addr != A_KEY) |=> (key_st == 2'd0));
  assert_pulse_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> tout_flag);
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(en) && $stable(cfg)));
  assert_kick_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!rst_req && !stage2));
endmodule

// File: tb/keyed_wdt_tb_top.sv
`timescale 1ns/1ps
module keyed_wdt_tb_top;
  localparam int PV_W = 4, LSH = 3, SSH = 1, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic rst_req, rst_warm, tout_flag, tog_out;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  keyed_wdt #(.PV_W(PV_W), .LONG_SH(LSH), .SHORT_SH(SSH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_req(rst_req), .rst_warm(rst_warm), .tout_flag(tout_flag), .tog_out(tog_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic key();
    wr(5'h0C, 8'h80);
    wr(5'h0C, 8'h86);
  endtask

  task automatic pwr(input logic [4:0] a, input logic [7:0] d);
    key();
    wr(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic setup(input int p1, input int p2, input logic [7:0] c);
    do_reset();
    wr(5'h10, c);
    pwr(5'h00, 8'(p1));
    pwr(5'h04, 8'(p2));
    pwr(5'h0D, 8'h01);
    wr(5'h18, 8'h02);
  endtask

  task automatic measure(input int win, output int h1, output int h2, output int nh);
    h1 = -1; h2 = -1; nh = 0;
    for (int k = 1; k <= win; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst_req) begin
        nh++;
        if (h1 < 0) h1 = k;
        else if (h2 < 0) h2 = k;
      end
    end
  endtask

  function automatic int period(input int p1, input int p2, input int sh);
    return ((p1 + 1) + (p2 + 1)) << sh;
  endfunction

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int h1, h2, nh, t;
    // R11 reset state
    do_reset();
    @(negedge clk);
    chk({rst_req, rst_warm, tout_flag, tog_out} == 4'b0, "R11 reset outputs",
        {rst_req, rst_warm, tout_flag, tog_out}, 0);
    measure(40, h1, h2, nh);
    chk(nh == 0, "R11 disabled after reset", nh, 0);

    // R4 R6 sweep
    for (int sel = 0; sel < 2; sel++)
      for (int p1 = 0; p1 < 4; p1++)
        for (int p2 = 0; p2 < 4; p2++) begin
          t = period(p1, p2, sel ? SSH : LSH);
          setup(p1, p2, 8'(8'h10 | (sel << 2)));
          measure(t + 3, h1, h2, nh);
          chk(h1 == t, "R4 timeout edge", h1, t);
          chk(nh == 1 && tout_flag, "R6 single pulse and flag", nh, 1);
        end

    // R6 restart of stage one
    setup(1, 2, 8'h10);
    t = period(1, 2, LSH);
    measure(2 * t + 2, h1, h2, nh);
    chk(h2 - h1 == t, "R6 restart period", h2 - h1, t);

    // R5 reload while disabled does not start
    do_reset();
    wr(5'h10, 8'h10);
    pwr(5'h0D, 8'h01);
    measure(100, h1, h2, nh);
    chk(nh == 0 && !tout_flag, "R5 disabled reload", nh, 0);

    // R5 periodic kicks hold off, last kick restarts
    setup(0, 0, 8'h10);
    t = period(0, 0, LSH);
    for (int i = 0; i < 10; i++) begin
      repeat (5) @(posedge clk);
      pwr(5'h0D, 8'h01);
    end
    chk(!tout_flag, "R5 kicks prevent timeout", tout_flag, 0);
    measure(t + 3, h1, h2, nh);
    chk(h1 == t, "R5 restart from kick", h1, t);

    // R1 unkeyed preload ignored
    do_reset();
    wr(5'h10, 8'h10);
    pwr(5'h00, 8'h00); pwr(5'h04, 8'h00);
    wr(5'h00, 8'h03);
    pwr(5'h0D, 8'h01); wr(5'h18, 8'h02);
    t = period(0, 0, LSH);
    measure(t + 3, h1, h2, nh);
    chk(h1 == t, "R1 unkeyed write ignored", h1, t);

    // R2 one guarded write per key
    do_reset();
    wr(5'h10, 8'h10);
    key(); wr(5'h00, 8'h01); wr(5'h04, 8'h03);
    pwr(5'h0D, 8'h01); wr(5'h18, 8'h02);
    t = period(1, 0, LSH);
    measure(t + 3, h1, h2, nh);
    chk(h1 == t, "R2 second write ignored", h1, t);

    // R3 wrong key byte cancels
    do_reset();
    wr(5'h10, 8'h10);
    wr(5'h0C, 8'h80); wr(5'h0C, 8'h81); wr(5'h0C, 8'h86); wr(5'h00, 8'h03);
    pwr(5'h0D, 8'h01); wr(5'h18, 8'h02);
    t = period(0, 0, LSH);
    measure(t + 3, h1, h2, nh);
    chk(h1 == t, "R3 wrong byte cancels", h1, t);

    // R3 intervening write cancels
    do_reset();
    wr(5'h10, 8'h10);
    key(); wr(5'h10, 8'h10); wr(5'h00, 8'h03);
    wr(5'h0C, 8'h80); wr(5'h18, 8'h00); wr(5'h0C, 8'h86); wr(5'h04, 8'h03);
    pwr(5'h0D, 8'h01); wr(5'h18, 8'h02);
    measure(t + 3, h1, h2, nh);
    chk(h1 == t, "R3 intervening write cancels", h1, t);

    // R7 flag clear needs key
    wr(5'h0D, 8'h02);
    @(negedge clk);
    chk(tout_flag == 1'b1, "R7 unkeyed clear ignored", tout_flag, 1);
    pwr(5'h0D, 8'h02);
    @(negedge clk);
    chk(tout_flag == 1'b0, "R7 keyed clear", tout_flag, 0);

    // R8 warm select and toggle
    setup(0, 0, 8'h18);
    chk(rst_warm == 1'b1, "R8 warm select", rst_warm, 1);
    measure(2 * t + 2, h1, h2, nh);
    chk(nh == 2 && tog_out == 1'b0, "R8 toggle twice", tog_out, 0);
    setup(0, 0, 8'h18);
    measure(t + 3, h1, h2, nh);
    chk(tog_out == 1'b1, "R8 toggle once", tog_out, 1);
    setup(0, 0, 8'h20);
    chk(rst_warm == 1'b0, "R8 cold select", rst_warm, 0);
    measure(t + 3, h1, h2, nh);
    chk(nh == 0 && tout_flag && !tog_out, "R8 R6 no reset, no toggle, flag set", nh, 0);

    // R9 lock freezes enable and configuration
    setup(0, 0, 8'h10);
    wr(5'h18, 8'h03);
    wr(5'h18, 8'h00);
    wr(5'h10, 8'h08);
    chk(rst_warm == 1'b0, "R9 config frozen", rst_warm, 0);
    measure(2 * t + 2, h1, h2, nh);
    chk(nh >= 1, "R9 cannot disable when locked", nh, 1);

    // R10 kick coincides with second-stage expiry
    setup(0, 0, 8'h10);
    repeat (t - 3) @(posedge clk);
    pwr(5'h0D, 8'h01);
    @(negedge clk);
    chk(!rst_req && !tout_flag, "R10 kick wins at expiry", rst_req, 0);
    measure(t + 3, h1, h2, nh);
    chk(h1 == t, "R10 full period after kick", h1, t);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule